// File: doc/BRIEF.md
# Radio Packet Transmit Sequencer

This block sits on the host side of a sub-GHz FSK transceiver and sends one complete radio packet over the transceiver's 16-bit serial command port. Payload bytes are first pushed into a small local buffer through a valid/ready stream. A single-cycle start pulse then carries the packet length. The block turns the transmitter on, reads the status word once, and writes the whole frame one byte per command. The frame is a fixed preamble, a two-byte sync word, the payload, an additive checksum and trailer bytes. At the end it turns the transmitter off and pulses `done`.

The transceiver pulls its active-low interrupt line low when it can accept the next byte. The sequencer synchronises that line and holds each byte write until the line is seen low. The serial side uses mode-0 framing: chip-select is held low for exactly one 16-bit word, the word goes out MSB first, and the receiver samples on the rising clock. Serial clock speed and the idle gap between words come from parameters.

Payload stream rules: `pl_ready` is high only while no packet is in flight and fewer than `MAX_PAY` bytes are held. A beat transfers on a clock edge where `pl_valid` and `pl_ready` are both high. The beats fill slots 0, 1, 2 and onward in arrival order. While `pl_ready` is low the producer must hold its beat, and the block does not take it. An accepted start empties the fill count, so the next packet's bytes begin again at slot 0.

Top module: `radio_tx_sequencer`

## Requirements
- R1: Every command is one chip-select-low window carrying exactly 16 SCK rising edges, sent MSB first. MOSI changes only while SCK is low. SCK is low whenever chip-select is high.
- R2: An accepted start issues these commands in order: 0x8239 (transmitter on), 0x0000 (status read), one write per frame byte, and 0x8201 (transmitter off). That is len+11 commands in total.
- R3: The frame byte order is 0xAA three times, 0x2D, 0xD4, payload slots 0..len-1, the checksum, and 0xAA twice.
- R4: Each frame byte is sent as the word 0xB800 plus the byte value. The word starts only after the synchronised `irq_n` has been seen low. While `irq_n` stays high, no byte write begins.
- R5: The checksum byte is the sum of the payload bytes modulo 256.
- R6: A length of 0 sends preamble, sync, checksum 0x00 and the trailer (8 byte writes). A length above MAX_PAY (16) is treated as 16.
- R7: `pl_ready` is high after reset. It is low once 16 bytes are held and low while a packet is in flight. Beats fill slots in arrival order, and an accepted start resets the fill position to slot 0.
- R8: Each SCK half-period lasts SCK_HALF system clocks (default 2, giving SCK at clk/4). Chip-select stays high for at least two SCK periods between commands.
- R9: `done` is a one-cycle pulse, issued exactly once per packet, after the chip-select of the transmitter-off command has returned high.
- R10: A start pulse that arrives while a packet is in flight is ignored. The packet in progress is not altered and no second packet follows.
- R11: After reset, `spi_cs_n` is 1, `spi_sck` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to send a packet |
| len | input | 5 | Payload length, sampled with `start` |
| pl_valid | input | 1 | Payload beat valid |
| pl_data | input | 8 | Payload beat byte |
| pl_ready | output | 1 | Buffer accepts a beat |
| irq_n | input | 1 | Transceiver ready line, active low, asynchronous |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the transceiver |
| spi_cs_n | output | 1 | Chip-select, active low |
| done | output | 1 | Packet finished pulse |

## Verification
Several properties are checked on every cycle by assertions:
- the serial framing: SCK idles low while deselected, MOSI is steady through each SCK high phase, each window carries 16 rising edges, and the deselect gap is at least two SCK periods;
- the rule that a byte state is entered only after a low synchronised interrupt;
- the single-cycle width of `done`;
- the fact that the transmitter-on step is entered only from idle.

Other behaviour only the bench scenarios can show: the full word sequence and its contents, checksum arithmetic across random payloads, the zero and over-range lengths, stream back-pressure at a full buffer and during a packet, and that a start issued mid-packet leaves no trace.

// File: rtl/rts_pkg.sv
package rts_pkg;
  localparam logic [15:0] CMD_TX_ON   = 16'h8239;
  localparam logic [15:0] CMD_TX_OFF  = 16'h8201;
  localparam logic [15:0] CMD_STATUS  = 16'h0000;
  localparam logic [15:0] CMD_WR_BASE = 16'hB800;
  localparam logic [7:0]  FILL_BYTE   = 8'hAA;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ON, SQ_STAT, SQ_WAIT, SQ_BYTE, SQ_OFF
  } seq_st_t;

  typedef enum logic [2:0] {
    SP_IDLE, SP_LEAD, SP_HIGH, SP_LOW, SP_TAIL, SP_GAP
  } spi_st_t;
endpackage

// File: rtl/rts_spi_engine.sv
module rts_spi_engine
  import rts_pkg::*;
#(
  parameter int HALF_CLKS = 2,
  parameter int WORD_W    = 16,
  parameter int GAP_SCK   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              cmd_ready,
  output logic              xfer_done,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n
);
  localparam int GAP_CLKS = 2 * HALF_CLKS * GAP_SCK;
  localparam int TW = $clog2(GAP_CLKS + 1);
  localparam int BW = $clog2(WORD_W);
  localparam logic [TW-1:0] HALF_END = TW'(HALF_CLKS - 1);
  localparam logic [TW-1:0] GAP_END  = TW'(GAP_CLKS - 1);
  localparam logic [BW-1:0] BIT_END  = BW'(WORD_W - 1);

  spi_st_t           st;
  logic [TW-1:0]     tick;
  logic [BW-1:0]     bit_idx;
  logic [WORD_W-1:0] shreg;
  logic              half_end;

  assign half_end  = (tick == HALF_END);
  assign cmd_ready = (st == SP_IDLE);
  assign mosi      = shreg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SP_IDLE;
      tick      <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      sck       <= 1'b0;
      cs_n      <= 1'b1;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      case (st)
        SP_IDLE: begin
          tick <= '0;
          if (cmd_valid) begin
            shreg <= cmd_word;
            cs_n  <= 1'b0;
            st    <= SP_LEAD;
          end
        end
        SP_LEAD: begin
          if (half_end) begin
            tick    <= '0;
            sck     <= 1'b1;
            bit_idx <= '0;
            st      <= SP_HIGH;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        SP_HIGH: begin
          if (half_end) begin
            tick <= '0;
            sck  <= 1'b0;
            if (bit_idx == BIT_END) begin
              st <= SP_TAIL;
            end else begin
              shreg   <= {shreg[WORD_W-2:0], 1'b0};
              bit_idx <= bit_idx + 1'b1;
              st      <= SP_LOW;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        SP_LOW: begin
          if (half_end) begin
            tick <= '0;
            sck  <= 1'b1;
            st   <= SP_HIGH;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        SP_TAIL: begin
          if (half_end) begin
            tick <= '0;
            cs_n <= 1'b1;
            st   <= SP_GAP;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        SP_GAP: begin
          if (tick == GAP_END) begin
            tick      <= '0;
            xfer_done <= 1'b1;
            st        <= SP_IDLE;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: st <= SP_IDLE;
      endcase
    end
  end

  // Checker state: deselect run length and rising edges per window
  localparam int GW = $clog2(GAP_CLKS + 2);
  localparam int EW = $clog2(WORD_W + 1);
  logic [GW-1:0] gap_cnt;
  logic [EW-1:0] edge_cnt;
  logic          sck_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt  <= GW'(GAP_CLKS);
      edge_cnt <= '0;
      sck_d    <= 1'b0;
    end else begin
      sck_d <= sck;
      if (cs_n) begin
        if (gap_cnt != GW'(GAP_CLKS)) gap_cnt <= gap_cnt + 1'b1;
      end else begin
        gap_cnt <= '0;
      end
      if (cs_n) edge_cnt <= '0;
      else if (sck && !sck_d) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  a_r1_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r1_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  a_r1_sixteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (edge_cnt == EW'(WORD_W)));

  a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (gap_cnt >= GW'(GAP_CLKS)));
endmodule

// File: rtl/rts_payload_buf.sv
module rts_payload_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DW-1:0]            in_data,
  output logic                     in_ready,
  input  logic                     lock,
  input  logic                     clear,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr;
  logic          take;

  assign in_ready = !lock && (wptr < PW'(DEPTH));
  assign take     = in_valid && in_ready;
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)     wptr <= '0;
    else if (clear) wptr <= '0;
    else if (take)  wptr <= wptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) mem[AW'(wptr)] <= in_data;
  end

  a_r7_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr == PW'(DEPTH)) |=> (wptr == PW'(DEPTH)) || (wptr == '0));
endmodule

// File: rtl/rts_frame_mux.sv
module rts_frame_mux
  import rts_pkg::*;
#(
  parameter int           MAX_PAY = 16,
  parameter int           PRE_N   = 3,
  parameter int           TRAIL_N = 2,
  parameter logic [7:0]   SYNC_HI = 8'h2D,
  parameter logic [7:0]   SYNC_LO = 8'hD4,
  parameter int           LEN_W   = 5,
  parameter int           IDX_W   = 5,
  parameter int           AW      = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       csum,
  input  logic [7:0]       pay_byte,
  output logic [AW-1:0]    pay_idx,
  output logic [7:0]       byte_o,
  output logic             is_pay,
  output logic             is_last
);
  localparam int PAY0 = PRE_N + 2;

  logic [IDX_W-1:0] ck_idx;
  logic [IDX_W-1:0] last_idx;

  assign ck_idx   = IDX_W'(PAY0) + IDX_W'(len);
  assign last_idx = ck_idx + IDX_W'(TRAIL_N);
  assign pay_idx  = AW'(idx - IDX_W'(PAY0));
  assign is_last  = (idx == last_idx);
  assign is_pay   = (idx >= IDX_W'(PAY0)) && (idx < ck_idx);

  always_comb begin
    if (idx < IDX_W'(PRE_N))        byte_o = FILL_BYTE;
    else if (idx == IDX_W'(PRE_N))  byte_o = SYNC_HI;
    else if (idx == IDX_W'(PRE_N + 1)) byte_o = SYNC_LO;
    else if (is_pay)                byte_o = pay_byte;
    else if (idx == ck_idx)         byte_o = csum;
    else                            byte_o = FILL_BYTE;
  end
endmodule

// File: rtl/rts_seq_fsm.sv
module rts_seq_fsm
  import rts_pkg::*;
#(
  parameter int MAX_PAY = 16,
  parameter int LEN_W   = 5,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic             irq_s,
  input  logic             cmd_ready,
  input  logic             xfer_done,
  input  logic [7:0]       frame_byte,
  input  logic             is_pay,
  input  logic             is_last,
  output logic             cmd_valid,
  output logic [15:0]      cmd_word,
  output logic [IDX_W-1:0] idx,
  output logic [LEN_W-1:0] len_q,
  output logic [7:0]       csum,
  output logic             busy,
  output logic             clear_fill,
  output logic             done
);
  seq_st_t st;
  logic    issued;
  logic    cmd_state;

  assign busy       = (st != SQ_IDLE);
  assign clear_fill = start && (st == SQ_IDLE);
  assign cmd_state  = (st == SQ_ON) || (st == SQ_STAT) || (st == SQ_BYTE) || (st == SQ_OFF);
  assign cmd_valid  = cmd_state && !issued;

  always_comb begin
    case (st)
      SQ_ON:   cmd_word = CMD_TX_ON;
      SQ_STAT: cmd_word = CMD_STATUS;
      SQ_BYTE: cmd_word = CMD_WR_BASE | {8'h00, frame_byte};
      SQ_OFF:  cmd_word = CMD_TX_OFF;
      default: cmd_word = CMD_STATUS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      issued <= 1'b0;
      idx    <= '0;
      len_q  <= '0;
      csum   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd_valid && cmd_ready) issued <= 1'b1;
      case (st)
        SQ_IDLE: begin
          issued <= 1'b0;
          if (start) begin
            len_q <= (len_in > LEN_W'(MAX_PAY)) ? LEN_W'(MAX_PAY) : len_in;
            idx   <= '0;
            csum  <= '0;
            st    <= SQ_ON;
          end
        end
        SQ_ON: if (xfer_done) begin
          issued <= 1'b0;
          st     <= SQ_STAT;
        end
        SQ_STAT: if (xfer_done) begin
          issued <= 1'b0;
          st     <= SQ_WAIT;
        end
        SQ_WAIT: if (!irq_s) st <= SQ_BYTE;
        SQ_BYTE: if (xfer_done) begin
          issued <= 1'b0;
          if (is_pay) csum <= csum + frame_byte;
          if (is_last) begin
            st <= SQ_OFF;
          end else begin
            idx <= idx + 1'b1;
            st  <= SQ_WAIT;
          end
        end
        SQ_OFF: if (xfer_done) begin
          issued <= 1'b0;
          done   <= 1'b1;
          st     <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  a_r4_byte_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_BYTE && $past(st) == SQ_WAIT) |-> !$past(irq_s));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_on_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_ON && $past(st) != SQ_ON) |-> ($past(st) == SQ_IDLE));

  a_r2_off_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_OFF && $past(st) == SQ_BYTE) |-> $past(is_last));
endmodule

// File: rtl/radio_tx_sequencer.sv
module radio_tx_sequencer
  import rts_pkg::*;
#(
  parameter int         MAX_PAY  = 16,
  parameter int         SCK_HALF = 2,
  parameter int         PRE_N    = 3,
  parameter int         TRAIL_N  = 2,
  parameter logic [7:0] SYNC_HI  = 8'h2D,
  parameter logic [7:0] SYNC_LO  = 8'hD4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [4:0] len,
  input  logic       pl_valid,
  input  logic [7:0] pl_data,
  output logic       pl_ready,
  input  logic       irq_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  output logic       spi_cs_n,
  output logic       done
);
  localparam int LEN_W = 5;
  localparam int AW    = $clog2(MAX_PAY);
  localparam int IDX_W = $clog2(PRE_N + 2 + MAX_PAY + 1 + TRAIL_N);

  logic [1:0]       irq_sync;
  logic             cmd_valid, cmd_ready, xfer_done;
  logic [15:0]      cmd_word;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       csum, frame_byte, pay_byte;
  logic [AW-1:0]    pay_idx;
  logic             is_pay, is_last, busy, clear_fill;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_sync <= 2'b11;
    else        irq_sync <= {irq_sync[0], irq_n};
  end

  rts_payload_buf #(.DEPTH(MAX_PAY), .DW(8)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pl_valid), .in_data(pl_data), .in_ready(pl_ready),
    .lock(busy), .clear(clear_fill),
    .rd_idx(pay_idx), .rd_data(pay_byte)
  );

  rts_frame_mux #(
    .MAX_PAY(MAX_PAY), .PRE_N(PRE_N), .TRAIL_N(TRAIL_N),
    .SYNC_HI(SYNC_HI), .SYNC_LO(SYNC_LO),
    .LEN_W(LEN_W), .IDX_W(IDX_W), .AW(AW)
  ) u_mux (
    .idx(idx), .len(len_q), .csum(csum), .pay_byte(pay_byte),
    .pay_idx(pay_idx), .byte_o(frame_byte), .is_pay(is_pay), .is_last(is_last)
  );

  rts_seq_fsm #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .len_in(len),
    .irq_s(irq_sync[1]), .cmd_ready(cmd_ready), .xfer_done(xfer_done),
    .frame_byte(frame_byte), .is_pay(is_pay), .is_last(is_last),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .idx(idx), .len_q(len_q),
    .csum(csum), .busy(busy), .clear_fill(clear_fill), .done(done)
  );

  rts_spi_engine #(.HALF_CLKS(SCK_HALF), .WORD_W(16), .GAP_SCK(2)) u_spi (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
    .xfer_done(xfer_done), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );
endmodule

// File: tb/tb_radio_tx_sequencer.sv
module tb_radio_tx_sequencer;
  localparam int SCK_HALF = 2;
  localparam int MAXP     = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pl_valid = 1'b0, irq_n = 1'b0;
  logic [4:0] len = '0;
  logic [7:0] pl_data = '0;
  logic pl_ready, spi_sck, spi_mosi, spi_cs_n, done;

  always #2 clk = ~clk;

  radio_tx_sequencer #(.MAX_PAY(MAXP), .SCK_HALF(SCK_HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
    .irq_n(irq_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .done(done)
  );

  int tests = 0, fails = 0, cyc = 0;
  logic [15:0] words [64];
  int mon_n, done_cnt, done_at, mosi_bad, half_bad, bits_bad, irq_bad, min_gap;
  int hold = 0, hi_run = 0, gap_run = 1000, nb = 0;
  logic [15:0] sh = '0;
  logic p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0, irq_at_fall = 1'b0;
  logic [7:0] pay [MAXP];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sum8(int n);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < n; i++) s = s + pay[i];
    return s;
  endfunction

  // Transceiver model and bus monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    cyc++;
    if (!spi_cs_n && spi_sck && !p_sck) begin sh = {sh[14:0], spi_mosi}; nb++; end
    if (spi_sck && p_sck && spi_mosi != p_mosi) mosi_bad++;
    if (spi_sck) hi_run++;
    else if (p_sck) begin if (hi_run != SCK_HALF) half_bad++; hi_run = 0; end
    if (spi_cs_n && spi_sck) mosi_bad++;
    if (spi_cs_n) gap_run++;
    if (!spi_cs_n && p_cs) begin
      if (gap_run < min_gap) min_gap = gap_run;
      gap_run = 0; nb = 0; irq_at_fall = irq_n;
    end
    if (spi_cs_n && !p_cs) begin
      if (mon_n < 64) words[mon_n] = sh;
      if (nb != 16) bits_bad++;
      if (sh[15:8] == 8'hB8) begin
        if (irq_at_fall) irq_bad++;
        hold = $urandom_range(60, 0);
      end
      mon_n++;
    end
    if (done) begin done_cnt++; done_at = mon_n; end
    if (hold > 0) hold--;
    irq_n = (hold != 0);
    p_sck = spi_sck; p_cs = spi_cs_n; p_mosi = spi_mosi;
  end

  initial begin
    @(negedge clk);
    while (cyc < 190000) @(negedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic load(int n);
    for (int i = 0; i < n; i++) begin
      pl_valid = 1'b0;
      repeat ($urandom_range(2, 0)) @(negedge clk);
      pl_data = pay[i]; pl_valid = 1'b1;
      while (!pl_ready) @(negedge clk);
      @(negedge clk);
    end
    pl_valid = 1'b0;
  endtask

  task automatic run_pkt(int len_in, bit poke);
    int eff, total, w, k;
    logic [15:0] exp_w [64];
    eff = (len_in > MAXP) ? MAXP : len_in;
    for (int i = 0; i < MAXP; i++) pay[i] = 8'($urandom);
    load(eff);
    if (eff == MAXP) chk(pl_ready == 1'b0, "R7", "ready low when full", pl_ready, 0);
    w = 0;
    exp_w[w++] = 16'h8239; exp_w[w++] = 16'h0000;
    for (int i = 0; i < 3; i++) exp_w[w++] = 16'hB8AA;
    exp_w[w++] = 16'hB82D; exp_w[w++] = 16'hB8D4;
    for (int i = 0; i < eff; i++) exp_w[w++] = {8'hB8, pay[i]};
    exp_w[w++] = {8'hB8, sum8(eff)};
    exp_w[w++] = 16'hB8AA; exp_w[w++] = 16'hB8AA;
    exp_w[w++] = 16'h8201;
    total = w;
    mon_n = 0; done_cnt = 0; done_at = -1; mosi_bad = 0; half_bad = 0;
    bits_bad = 0; irq_bad = 0; min_gap = 1000;
    @(negedge clk); start = 1'b1; len = 5'(len_in);
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (200) @(negedge clk);
      chk(pl_ready == 1'b0, "R7", "ready low while busy", pl_ready, 0);
      pl_valid = 1'b1; pl_data = 8'h5A; start = 1'b1; len = 5'd3;
      @(negedge clk); pl_valid = 1'b0; start = 1'b0;
    end
    k = 0;
    while (done_cnt == 0 && k < 60000) begin @(negedge clk); k++; end
    repeat (400) @(negedge clk);
    chk(mon_n == total, "R2", "command count", mon_n, total);
    for (int i = 0; i < total && i < mon_n; i++)
      chk(words[i] == exp_w[i], (i == total - 2 - 2) ? "R5" : "R3", "word", words[i], exp_w[i]);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(done_at == total, "R9", "done after off command", done_at, total);
    chk(irq_bad == 0, "R4", "write with irq high", irq_bad, 0);
    chk(mosi_bad == 0 && bits_bad == 0, "R1", "framing faults", mosi_bad + bits_bad, 0);
    chk(half_bad == 0, "R8", "sck half period faults", half_bad, 0);
    chk(min_gap >= 4 * SCK_HALF, "R8", "min cs gap", min_gap, 4 * SCK_HALF);
    if (poke) chk(mon_n == total, "R10", "start while busy ignored", mon_n, total);
    if (len_in == 0) chk(words[7] == 16'hB800, "R6", "zero length checksum", words[7], 16'hB800);
    if (len_in > MAXP) chk(mon_n == MAXP + 11, "R6", "length clamped", mon_n, MAXP + 11);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R11", "cs_n at reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R11", "sck at reset", spi_sck, 0);
    chk(done == 1'b0, "R11", "done at reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pl_ready == 1'b1, "R7", "ready after reset", pl_ready, 1);
    run_pkt(16, 1'b0);
    run_pkt(1, 1'b0);
    run_pkt(0, 1'b0);
    run_pkt(20, 1'b0);
    run_pkt(5, 1'b1);
    for (int r = 0; r < 6; r++) run_pkt($urandom_range(16, 1), r[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule